// File: doc/BRIEF.md
# Memory and I/O Address Decoder with Write Strobe Qualification

This block is the glue logic between an 8-bit microprocessor with a 16-bit address bus and its memories and peripherals. It turns each address into exactly one active-low chip select. The low half of the space goes to RAM and the upper half to ROM. The exception is a small device area at the start of the top page. Within that area, four serial devices each take a 4-byte window and three parallel-interface devices each take a 16-byte window. The remainder of the top page falls back to ROM.

The block also shapes the memory strobes from the processor's read/write line and its PHI2 clock phase. RAM write-enable is driven only during PHI2 high of a write cycle to a RAM address. While PHI2 is low, addresses and data are still settling, so a write strobe then could corrupt a cell. Memory output-enable follows the read level of R/W. A parameter chooses whether output-enable also waits for PHI2 high. ROM write-enable is held inactive, so software cannot reprogram the ROM. The decode has two stages: the first detects the top page and the second splits its low byte into device windows.

Top module: `glue_addr_decode`

## Requirements
- R1: Addresses 0x0000 to 0x7FFF assert only `ramCsN` (low); all other selects stay high.
- R2: Addresses 0x8000 to 0xFEFF and 0xFF40 to 0xFFFF assert only `romCsN`.
- R3: Within 0xFF00 to 0xFF0F, `serCsN[k]` (bit k, k = 0..3) is low for 0xFF00 + 4k to 0xFF03 + 4k, with no other select low.
- R4: `parCsN[k]` (bit k, k = 0..2) is low for 0xFF10 + 16k to 0xFF1F + 16k, with no other select low.
- R5: Out of reset, exactly one of the nine selects is low for every address, whatever the levels of R/W and PHI2.
- R6: `ramWeN` is low only while `phi2` is high, `rw` is low (write) and the address is in the RAM range; it is high for writes to ROM or device addresses.
- R7: `memOeN` is high whenever `rw` is low. With `rw` high it is low for the whole cycle when `OE_QUALIFY` is 0, and only while `phi2` is high when `OE_QUALIFY` is 1.
- R8: `romWeN` is high at all times.
- R9: While `rstN` is low, all chip selects, `ramWeN` and `memOeN` are high, whatever the address, `rw` and `phi2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| rw | input | 1 | Processor read/write line, high = read |
| phi2 | input | 1 | Processor clock phase 2, high = bus data valid |
| rstN | input | 1 | Active-low system reset |
| ramCsN | output | 1 | RAM chip select, active low |
| romCsN | output | 1 | ROM chip select, active low |
| serCsN | output | 4 | Serial device selects, active low, bit k = device k |
| parCsN | output | 3 | Parallel-interface device selects, active low |
| ramWeN | output | 1 | RAM write-enable, active low |
| memOeN | output | 1 | Memory output-enable, active low |
| romWeN | output | 1 | ROM write-enable, held high |

## Verification
The bench builds two copies of the block: one with the default `OE_QUALIFY` of 0 and one with `OE_QUALIFY` set to 1. It drives both with the same inputs, so in a single run it can compare the full-cycle read enable against the PHI2-qualified one. The window geometry parameters keep their defaults. These defaults put the edges of every device window (0xFF03/0xFF04, 0xFF0F/0xFF10, 0xFF3F/0xFF40) and the RAM/ROM split at 0x7FFF/0x8000 in reach of directed vectors.

// File: rtl/glue_pkg.sv
package glue_pkg;
  // Strobe requests from the control half to the datapath half
  typedef struct packed {
    logic ramWrite;
    logic memRead;
  } strobe_t;

  localparam int DEF_ADDR_W       = 16;
  localparam int DEF_SER_SPAN_LOG = 2;
  localparam int DEF_PAR_SPAN_LOG = 4;
  localparam int DEF_PAR_COUNT    = 3;
endpackage

// File: rtl/glue_strobe_ctrl.sv
module glue_strobe_ctrl
  import glue_pkg::*;
#(
  parameter bit OE_QUALIFY = 1'b0
) (
  input  logic    rw,
  input  logic    phi2,
  input  logic    rstN,
  input  logic    ramHit,
  output strobe_t strobes
);

  logic readLevel;

  generate
    if (OE_QUALIFY) begin : g_oe_phase
      assign readLevel = rw && phi2;
    end else begin : g_oe_full
      assign readLevel = rw;
    end
  endgenerate

  always_comb begin
    strobes.ramWrite = rstN && ramHit && !rw && phi2;
    strobes.memRead  = rstN && readLevel;
  end

  // R6: sampled just before PHI2 rises, the phase is low, so no write strobe
  p_no_we_phase_low_r6: assert property (@(posedge phi2) disable iff (!rstN)
    !strobes.ramWrite);

  // R7: a write cycle never carries a read request
  p_no_read_on_write_r7: assert property (@(negedge phi2) disable iff (!rstN)
    !rw |-> !strobes.memRead);

endmodule

// File: rtl/glue_dec_path.sv
module glue_dec_path
  import glue_pkg::*;
#(
  parameter int ADDR_W       = DEF_ADDR_W,
  parameter int SER_SPAN_LOG = DEF_SER_SPAN_LOG,
  parameter int PAR_SPAN_LOG = DEF_PAR_SPAN_LOG,
  parameter int PAR_COUNT    = DEF_PAR_COUNT,
  localparam int PAGE_W      = ADDR_W - 8,
  localparam int SER_COUNT   = 1 << (PAR_SPAN_LOG - SER_SPAN_LOG)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rstN,
  input  logic                 phi2,
  input  strobe_t              strobes,
  output logic                 ramHit,
  output logic                 ramCsN,
  output logic                 romCsN,
  output logic [SER_COUNT-1:0] serCsN,
  output logic [PAR_COUNT-1:0] parCsN,
  output logic                 ramWeN,
  output logic                 memOeN,
  output logic                 romWeN
);

  localparam int IDX_W  = PAR_SPAN_LOG - SER_SPAN_LOG;
  localparam int IO_END = (PAR_COUNT + 1) << PAR_SPAN_LOG;
  localparam logic [PAGE_W-1:0] IO_PAGE = '1;

  // Stage one: top page detection
  logic       pageHit;
  logic [7:0] lowByte;
  logic       ioHit;
  logic [7:0] slot;
  logic [IDX_W-1:0] serIdx;

  always_comb begin
    lowByte = addr[7:0];
    pageHit = (addr[ADDR_W-1 -: PAGE_W] == IO_PAGE);
    ioHit   = pageHit && ({1'b0, lowByte} < 9'(IO_END));
    slot    = lowByte >> PAR_SPAN_LOG;
    serIdx  = lowByte[PAR_SPAN_LOG-1:SER_SPAN_LOG];
  end

  // Stage two: device windows in the low byte
  logic [SER_COUNT-1:0] serHit;
  logic [PAR_COUNT-1:0] parHit;
  logic                 romHit;

  generate
    for (genvar s = 0; s < SER_COUNT; s++) begin : g_ser
      assign serHit[s] = ioHit && (slot == 8'd0) && (serIdx == IDX_W'(s));
    end
    for (genvar p = 0; p < PAR_COUNT; p++) begin : g_par
      assign parHit[p] = ioHit && (slot == 8'(p + 1));
    end
  endgenerate

  assign ramHit = !addr[ADDR_W-1];
  assign romHit = addr[ADDR_W-1] && !ioHit;

  // Reset gating and active-low pin drive
  always_comb begin
    ramCsN = !(rstN && ramHit);
    romCsN = !(rstN && romHit);
    serCsN = ~(serHit & {SER_COUNT{rstN}});
    parCsN = ~(parHit & {PAR_COUNT{rstN}});
    ramWeN = !strobes.ramWrite;
    memOeN = !strobes.memRead;
    romWeN = 1'b1;
  end

  // R5: exactly one select low out of reset
  p_one_select_r5: assert property (@(negedge phi2) disable iff (!rstN)
    $countones({parCsN, serCsN, romCsN, ramCsN}) == SER_COUNT + PAR_COUNT + 1);

  // R1: RAM select only in the low half
  p_ram_low_half_r1: assert property (@(negedge phi2) disable iff (!rstN)
    !ramCsN |-> !addr[ADDR_W-1]);

  // R6: a RAM write strobe travels with the RAM select
  p_we_with_select_r6: assert property (@(negedge phi2) disable iff (!rstN)
    !ramWeN |-> !ramCsN);

  // R9: reset holds every select and strobe inactive
  p_reset_quiet_r9: assert property (@(negedge phi2)
    !rstN |-> (ramCsN && romCsN && (&serCsN) && (&parCsN) && ramWeN && memOeN));

endmodule

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import glue_pkg::*;
#(
  parameter bit OE_QUALIFY = 1'b0
) (
  input  logic [15:0] addr,
  input  logic        rw,
  input  logic        phi2,
  input  logic        rstN,
  output logic        ramCsN,
  output logic        romCsN,
  output logic [3:0]  serCsN,
  output logic [2:0]  parCsN,
  output logic        ramWeN,
  output logic        memOeN,
  output logic        romWeN
);

  strobe_t strobes;
  logic    ramHit;

  glue_strobe_ctrl #(
    .OE_QUALIFY(OE_QUALIFY)
  ) u_ctrl (
    .rw     (rw),
    .phi2   (phi2),
    .rstN   (rstN),
    .ramHit (ramHit),
    .strobes(strobes)
  );

  glue_dec_path #(
    .ADDR_W      (16),
    .SER_SPAN_LOG(2),
    .PAR_SPAN_LOG(4),
    .PAR_COUNT   (3)
  ) u_path (
    .addr   (addr),
    .rstN   (rstN),
    .phi2   (phi2),
    .strobes(strobes),
    .ramHit (ramHit),
    .ramCsN (ramCsN),
    .romCsN (romCsN),
    .serCsN (serCsN),
    .parCsN (parCsN),
    .ramWeN (ramWeN),
    .memOeN (memOeN),
    .romWeN (romWeN)
  );

endmodule

// File: tb/tb_glue_addr_decode.sv
module tb_glue_addr_decode;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [15:0] addr;
  logic rw, phi2, rstN;
  logic ramCsN, romCsN, ramWeN, memOeN, romWeN;
  logic [3:0] serCsN;
  logic [2:0] parCsN;
  logic ramCsNQ, romCsNQ, ramWeNQ, memOeNQ, romWeNQ;
  logic [3:0] serCsNQ;
  logic [2:0] parCsNQ;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  glue_addr_decode #(.OE_QUALIFY(1'b0)) dut (
    .addr(addr), .rw(rw), .phi2(phi2), .rstN(rstN),
    .ramCsN(ramCsN), .romCsN(romCsN), .serCsN(serCsN), .parCsN(parCsN),
    .ramWeN(ramWeN), .memOeN(memOeN), .romWeN(romWeN));

  glue_addr_decode #(.OE_QUALIFY(1'b1)) dutQ (
    .addr(addr), .rw(rw), .phi2(phi2), .rstN(rstN),
    .ramCsN(ramCsNQ), .romCsN(romCsNQ), .serCsN(serCsNQ), .parCsN(parCsNQ),
    .ramWeN(ramWeNQ), .memOeN(memOeNQ), .romWeN(romWeNQ));

  // Select vector {parCsN[2:0], serCsN[3:0], romCsN, ramCsN}
  localparam logic [8:0] S_RAM = 9'h1FE, S_ROM = 9'h1FD, S_OFF = 9'h1FF;
  localparam logic [8:0] S_SER0 = 9'h1FB, S_SER1 = 9'h1F7, S_SER2 = 9'h1EF, S_SER3 = 9'h1DF;
  localparam logic [8:0] S_PAR0 = 9'h1BF, S_PAR1 = 9'h17F, S_PAR2 = 9'h0FF;

  localparam int NVEC = 20;
  localparam logic [24:0] VEC [NVEC] = '{
    {16'h0000, S_RAM},  {16'h4000, S_RAM},  {16'h7FFF, S_RAM},
    {16'h8000, S_ROM},  {16'hC123, S_ROM},  {16'hFEFF, S_ROM},
    {16'hFF00, S_SER0}, {16'hFF03, S_SER0}, {16'hFF04, S_SER1},
    {16'hFF0B, S_SER2}, {16'hFF0C, S_SER3}, {16'hFF0F, S_SER3},
    {16'hFF10, S_PAR0}, {16'hFF1F, S_PAR0}, {16'hFF20, S_PAR1},
    {16'hFF30, S_PAR2}, {16'hFF3F, S_PAR2}, {16'hFF40, S_ROM},
    {16'hFF80, S_ROM},  {16'hFFFF, S_ROM}
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (addr %h rw %b phi2 %b)", req, got, exp, addr, rw, phi2);
    end
  endtask

  function automatic logic [8:0] sel();
    return {parCsN, serCsN, romCsN, ramCsN};
  endfunction

  function automatic logic [8:0] selQ();
    return {parCsNQ, serCsNQ, romCsNQ, ramCsNQ};
  endfunction

  task automatic apply(input logic [15:0] a, input logic r, input logic p);
    addr = a; rw = r; phi2 = p;
    #3;
  endtask

  initial begin
    rstN = 1'b0; addr = 16'h0000; rw = 1'b0; phi2 = 1'b1;
    #3;
    // R9: reset state, RAM write in PHI2 high would otherwise strobe
    check("R9 selects in reset", sel(), S_OFF);
    check("R9 strobes in reset", {7'd0, ramWeN, memOeN}, 9'd3);
    apply(16'hFF05, 1'b1, 1'b1);
    check("R9 device addr in reset", sel(), S_OFF);
    check("R9 read in reset", {7'd0, memOeN, memOeNQ}, 9'd3);
    check("R8 romWeN in reset", {8'd0, romWeN}, 9'd1);
    #5;
    rstN = 1'b1;
    #3;

    // Vector table: R1..R5 over both PHI2 phases and both R/W levels
    for (int i = 0; i < NVEC; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [8:0] e;
        e = VEC[i][8:0];
        apply(VEC[i][24:9], m[0], m[1]);
        if (e == S_RAM) check("R1 ram window", sel(), e);
        else if (e == S_ROM) check("R2 rom window", sel(), e);
        else if (e[5:2] != 4'hF) check("R3 serial window", sel(), e);
        else check("R4 parallel window", sel(), e);
        check("R5 one select both builds", selQ(), e);
      end
    end

    // R6: RAM write strobe
    apply(16'h1234, 1'b0, 1'b0);
    check("R6 write phi2 low", {8'd0, ramWeN}, 9'd1);
    apply(16'h1234, 1'b0, 1'b1);
    check("R6 write phi2 high", {8'd0, ramWeN}, 9'd0);
    check("R6 write phi2 high qual build", {8'd0, ramWeNQ}, 9'd0);
    apply(16'h1234, 1'b1, 1'b1);
    check("R6 read no write strobe", {8'd0, ramWeN}, 9'd1);
    apply(16'h9000, 1'b0, 1'b1);
    check("R6 rom write no strobe", {8'd0, ramWeN}, 9'd1);
    apply(16'hFF08, 1'b0, 1'b1);
    check("R6 device write no strobe", {8'd0, ramWeN}, 9'd1);
    apply(16'h7FFF, 1'b0, 1'b1);
    check("R6 top ram write", {8'd0, ramWeN}, 9'd0);

    // R7: output enable in both builds
    apply(16'h0100, 1'b1, 1'b0);
    check("R7 read phi2 low full", {8'd0, memOeN}, 9'd0);
    check("R7 read phi2 low qualified", {8'd0, memOeNQ}, 9'd1);
    apply(16'h0100, 1'b1, 1'b1);
    check("R7 read phi2 high full", {8'd0, memOeN}, 9'd0);
    check("R7 read phi2 high qualified", {8'd0, memOeNQ}, 9'd0);
    apply(16'hA000, 1'b0, 1'b1);
    check("R7 write blocks oe", {7'd0, memOeN, memOeNQ}, 9'd3);
    apply(16'hA000, 1'b0, 1'b0);
    check("R7 write phi2 low blocks oe", {7'd0, memOeN, memOeNQ}, 9'd3);

    // R8: ROM write-enable during a ROM write
    apply(16'hFFFC, 1'b0, 1'b1);
    check("R8 romWeN on rom write", {7'd0, romWeN, romWeNQ}, 9'd3);

    // R9: reset asserted mid-operation
    apply(16'h2000, 1'b0, 1'b1);
    rstN = 1'b0;
    #3;
    check("R9 reset mid write", {ramWeN, ramCsN, 7'd0}, {2'b11, 7'd0});
    rstN = 1'b1;
    #3;
    check("R1 after reset release", sel(), S_RAM);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule